// File: doc/BRIEF.md
# UART Register and Interrupt Block

This block is the software-visible face of a UART. It decodes a small word-addressed register window (eight 32-bit registers on 4-byte strides) and holds the control word, the FIFO trigger levels, a modem/command register and an interrupt mask. It also keeps the pending interrupt state. The serializers sit outside. They report to this block through one-cycle event strobes and a status word. A data-port access becomes a push strobe toward the transmit side, or a pop strobe toward the receive side.

Pending events are sticky. The cause register shows each event twice: once gated by the mask in its low half, and once raw in its upper half. Software acknowledges events by writing ones, so writing back the value just read clears exactly what was seen. Command bits have separate set and clear addresses, so no read-modify-write is needed. Two of the command bits are FIFO-reset strobes that never hold a level. The clear-to-send input is synchronized, reported inverted-active in the status word, and any change of it is latched and raised as the modem-status interrupt source.

Top module: `uart_regblk`

## Requirements
- R1: After reset, every register reads 0 except status bit 25, which reads 1 while the CTS input is high. `irq_o`, `cmd_o` and all strobes are low.
- R2: Byte offsets: control 0x00, status 0x04, data 0x08, mask 0x0C, cause 0x10, triggers 0x14, command-set 0x18, command-clear 0x1C. Control reads back all 32 written bits. Triggers keep only bits 4:0 (RX level), 11:8 (TX level) and 20:16 (flow level), so writing all ones reads back 0x001F0F1F.
- R3: An event strobe on `evt_i[k]` latches source k as pending. Pending source k reads in cause bit 16+k whatever the mask holds. The sources are k=0 modem status, 1 RX data available, 2 TX data needed, 3 RX timeout, 4 RX line error, 5 TX DMA done, 6 RX DMA done, 7 RX DMA timeout, 8 DTR rise and 9 DTR fall.
- R4: Cause bit k (k<10) reads pending[k] AND mask[k], where mask is mask-register bits 9:0. `irq_o` is the OR of those masked bits. It takes its new value in the cycle after the clock edge that accepts a mask or cause write.
- R5: Writing the cause register clears pending source k when wdata bit k or bit 16+k is 1. Zero bits leave the source unchanged, so writing back a read value acknowledges exactly those events.
- R6: When an event arrives in the same cycle as a write that clears it, the source stays pending.
- R7: Command bits 0..5 (RI, DCD, DSR, break, finish-and-wait, RTS) are set by writing 1 at 0x18 and cleared by writing 1 at 0x1C. Zero bits have no effect. Both addresses read the current command bits, and `cmd_o` drives them.
- R8: Command bits 6 (RX FIFO reset) and 7 (TX FIFO reset) are strobes. Writing 1 at 0x18 drives the matching `cmd_o` bit high for exactly the one cycle after the write. They always read back 0, and a write at 0x1C does not strobe them.
- R9: Status reads `sts_i`, except for two bits. Bit 25 is the synchronized CTS line level (0 means asserted). Bit 24 is a sticky flag that sets when that level changes and clears when 1 is written to status bit 24. The same change also latches source 0.
- R10: A write at 0x08 pulses `tx_push_o` in that cycle, with `tx_byte_o` = wdata[7:0]. A read at 0x08 returns `rx_byte_i` in bits 7:0 and pulses `rx_pop_o` in that cycle.
- R11: `uart_en_o` follows control bit 0, `loop_en_o` follows control bit 24, and `ctrl_o` carries the whole control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset; bits 1:0 ignored |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| evt_i | input | N_SRC | One-cycle event strobes, one per source |
| sts_i | input | 32 | Status bits from the serializers |
| cts_n_i | input | 1 | CTS line, low = asserted, asynchronous |
| rx_byte_i | input | 8 | Head of receive FIFO |
| rx_pop_o | output | 1 | Data-port read strobe |
| tx_push_o | output | 1 | Data-port write strobe |
| tx_byte_o | output | 8 | Byte to transmit |
| ctrl_o | output | 32 | Control word |
| uart_en_o | output | 1 | UART enable |
| loop_en_o | output | 1 | Loopback enable |
| trig_rx_o | output | 5 | RX trigger level |
| trig_tx_o | output | 4 | TX trigger level |
| afc_lvl_o | output | 5 | Auto-flow level |
| cmd_o | output | CMD_W | Command levels and FIFO-reset strobes |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions take for granted that the address decode never raises the command-set and command-clear writes together. They also assume that the event inputs are single-cycle strobes sampled on the clock, so that a pending bit changes only through an event or a cause write. The stimulus drives one register access per cycle, holds each event strobe for exactly one cycle, and changes the CTS line only during the directed phase. As a result, the random phase's model of pending bits never sees a synchronizer-delayed event it does not know about. Random mask writes, cause writes (raw, read-back and mixed halves), event bursts and command writes are mixed with directed cases for acknowledge-versus-event collisions and for the reset strobes.

// File: rtl/uart_regblk_pkg.sv
package uart_regblk_pkg;

   localparam int unsigned DATA_W        = 32;
   localparam int unsigned IDX_W         = 3;
   localparam int unsigned CAUSE_RAW_LSB = 16;
   localparam int unsigned STAT_DCTS_BIT = 24;
   localparam int unsigned STAT_CTS_BIT  = 25;
   localparam int unsigned CTRL_EN_BIT   = 0;
   localparam int unsigned CTRL_LOOP_BIT = 24;
   localparam logic [DATA_W-1:0] TRIG_KEEP = 32'h001F_0F1F;

   // register index = byte offset / 4
   typedef enum logic [IDX_W-1:0] {
      RI_CTRL  = 3'd0,
      RI_STAT  = 3'd1,
      RI_DATA  = 3'd2,
      RI_MASK  = 3'd3,
      RI_CAUSE = 3'd4,
      RI_TRIG  = 3'd5,
      RI_CSET  = 3'd6,
      RI_CCLR  = 3'd7
   } reg_idx_e;

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
   parameter int unsigned N_SRC = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_SRC-1:0] evt_i,
   input  logic             mask_we_i,
   input  logic [N_SRC-1:0] mask_wdata_i,
   input  logic             ack_we_i,
   input  logic [N_SRC-1:0] ack_bits_i,
   output logic [N_SRC-1:0] mask_o,
   output logic [N_SRC-1:0] pend_o,
   output logic             irq_o
);

   logic [N_SRC-1:0] mask_q;
   logic [N_SRC-1:0] pend_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        mask_q <= '0;
      else if (mask_we_i) mask_q <= mask_wdata_i;
   end

   for (genvar k = 0; k < N_SRC; k++) begin : g_src
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                       pend_q[k] <= 1'b0;
         else if (evt_i[k])                 pend_q[k] <= 1'b1;   // event beats ack
         else if (ack_we_i && ack_bits_i[k]) pend_q[k] <= 1'b0;
      end

      p_event_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         evt_i[k] |=> pend_q[k]);
      p_ack_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (ack_we_i && ack_bits_i[k] && !evt_i[k]) |=> !pend_q[k]);
   end

   assign mask_o = mask_q;
   assign pend_o = pend_q;
   assign irq_o  = |(pend_q & mask_q);

   p_pend_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ack_we_i && (evt_i == '0)) |=> $stable(pend_q));
   p_mask_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mask_we_i |=> (mask_q == $past(mask_wdata_i)));
   p_irq_needs_pend_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (pend_q != '0));

endmodule

// File: rtl/uart_cmd_reg.sv
module uart_cmd_reg #(
   parameter int unsigned     CMD_W      = 8,
   parameter logic [CMD_W-1:0] PULSE_MASK = 8'hC0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             set_we_i,
   input  logic             clr_we_i,
   input  logic [CMD_W-1:0] wdata_i,
   output logic [CMD_W-1:0] state_o,
   output logic [CMD_W-1:0] cmd_o
);

   logic [CMD_W-1:0] lvl_q;
   logic [CMD_W-1:0] pls_q;

   for (genvar k = 0; k < CMD_W; k++) begin : g_bit
      if (PULSE_MASK[k]) begin : g_pulse
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) pls_q[k] <= 1'b0;
            else         pls_q[k] <= set_we_i && wdata_i[k];
         end
         assign lvl_q[k] = 1'b0;

         p_pulse_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cmd_o[k] |-> $past(set_we_i && wdata_i[k]));
      end else begin : g_level
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                      lvl_q[k] <= 1'b0;
            else if (set_we_i && wdata_i[k])  lvl_q[k] <= 1'b1;
            else if (clr_we_i && wdata_i[k])  lvl_q[k] <= 1'b0;
         end
         assign pls_q[k] = 1'b0;

         p_cmd_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (set_we_i && wdata_i[k]) |=> state_o[k]);
         p_cmd_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_we_i && wdata_i[k]) |=> !state_o[k]);
      end
   end

   assign state_o = lvl_q;
   assign cmd_o   = lvl_q | pls_q;

   p_cmd_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(set_we_i && clr_we_i));

endmodule

// File: rtl/uart_cts_mon.sv
module uart_cts_mon #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic cts_n_i,
   input  logic dcts_clr_i,
   output logic cts_sync_o,
   output logic chg_o,
   output logic dcts_o
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   dcts_q;

   if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) sync_q <= '1;
         else         sync_q <= cts_n_i;
      end
   end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) sync_q <= '1;
         else         sync_q <= {sync_q[SYNC_STAGES-2:0], cts_n_i};
      end
   end

   assign cts_sync_o = sync_q[SYNC_STAGES-1];
   assign chg_o      = cts_sync_o ^ prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b1;
         dcts_q <= 1'b0;
      end else begin
         prev_q <= cts_sync_o;
         if (chg_o)           dcts_q <= 1'b1;
         else if (dcts_clr_i) dcts_q <= 1'b0;
      end
   end

   assign dcts_o = dcts_q;

   p_dcts_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chg_o |=> dcts_o);

endmodule

// File: rtl/uart_regblk.sv
module uart_regblk
   import uart_regblk_pkg::*;
#(
   parameter int unsigned      ADDR_W      = 5,
   parameter int unsigned      N_SRC       = 10,
   parameter int unsigned      CMD_W       = 8,
   parameter logic [CMD_W-1:0] PULSE_MASK  = 8'hC0,
   parameter int unsigned      SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   input  logic [N_SRC-1:0]  evt_i,
   input  logic [31:0]       sts_i,
   input  logic              cts_n_i,
   input  logic [7:0]        rx_byte_i,
   output logic              rx_pop_o,
   output logic              tx_push_o,
   output logic [7:0]        tx_byte_o,
   output logic [31:0]       ctrl_o,
   output logic              uart_en_o,
   output logic              loop_en_o,
   output logic [4:0]        trig_rx_o,
   output logic [3:0]        trig_tx_o,
   output logic [4:0]        afc_lvl_o,
   output logic [CMD_W-1:0]  cmd_o,
   output logic              irq_o
);

   localparam int unsigned WIN_W = IDX_W + 2;

   initial begin
      assert (ADDR_W >= WIN_W) else $error("ADDR_W too small for register window");
      assert (N_SRC >= 1 && N_SRC <= CAUSE_RAW_LSB) else $error("N_SRC out of range");
      assert (CMD_W >= 1 && CMD_W <= DATA_W) else $error("CMD_W out of range");
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be at least 1");
   end

   // ---------------- decode ----------------
   reg_idx_e idx;
   logic     hit;
   logic     wr_acc;
   logic     rd_acc;

   assign idx    = reg_idx_e'(bus_addr_i[WIN_W-1:2]);
   assign hit    = (bus_addr_i >> WIN_W) == '0;
   assign wr_acc = bus_sel_i && bus_wr_i && hit;
   assign rd_acc = bus_sel_i && !bus_wr_i && hit;

   logic we_ctrl, we_stat, we_mask, we_cause, we_trig, we_cset, we_cclr;
   assign we_ctrl  = wr_acc && (idx == RI_CTRL);
   assign we_stat  = wr_acc && (idx == RI_STAT);
   assign we_mask  = wr_acc && (idx == RI_MASK);
   assign we_cause = wr_acc && (idx == RI_CAUSE);
   assign we_trig  = wr_acc && (idx == RI_TRIG);
   assign we_cset  = wr_acc && (idx == RI_CSET);
   assign we_cclr  = wr_acc && (idx == RI_CCLR);

   assign tx_push_o = wr_acc && (idx == RI_DATA);
   assign rx_pop_o  = rd_acc && (idx == RI_DATA);
   assign tx_byte_o = bus_wdata_i[7:0];

   // ---------------- plain registers ----------------
   logic [31:0] ctrl_q;
   logic [31:0] trig_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
         trig_q <= '0;
      end else begin
         if (we_ctrl) ctrl_q <= bus_wdata_i;
         if (we_trig) trig_q <= bus_wdata_i & TRIG_KEEP;
      end
   end

   assign ctrl_o    = ctrl_q;
   assign uart_en_o = ctrl_q[CTRL_EN_BIT];
   assign loop_en_o = ctrl_q[CTRL_LOOP_BIT];
   assign trig_rx_o = trig_q[4:0];
   assign trig_tx_o = trig_q[11:8];
   assign afc_lvl_o = trig_q[20:16];

   // ---------------- CTS monitor ----------------
   logic cts_sync, cts_chg, dcts;

   uart_cts_mon #(.SYNC_STAGES(SYNC_STAGES)) cts_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cts_n_i    (cts_n_i),
      .dcts_clr_i (we_stat && bus_wdata_i[STAT_DCTS_BIT]),
      .cts_sync_o (cts_sync),
      .chg_o      (cts_chg),
      .dcts_o     (dcts)
   );

   // ---------------- interrupts ----------------
   logic [N_SRC-1:0] evt_all, ack_bits, mask, pend;

   always_comb begin
      evt_all    = evt_i;
      evt_all[0] = evt_i[0] | cts_chg;
   end

   assign ack_bits = bus_wdata_i[N_SRC-1:0] | bus_wdata_i[CAUSE_RAW_LSB +: N_SRC];

   uart_irq_ctrl #(.N_SRC(N_SRC)) irq_ctl_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .evt_i        (evt_all),
      .mask_we_i    (we_mask),
      .mask_wdata_i (bus_wdata_i[N_SRC-1:0]),
      .ack_we_i     (we_cause),
      .ack_bits_i   (ack_bits),
      .mask_o       (mask),
      .pend_o       (pend),
      .irq_o        (irq_o)
   );

   // ---------------- command register ----------------
   logic [CMD_W-1:0] cmd_state;

   uart_cmd_reg #(.CMD_W(CMD_W), .PULSE_MASK(PULSE_MASK)) cmd_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_we_i (we_cset),
      .clr_we_i (we_cclr),
      .wdata_i  (bus_wdata_i[CMD_W-1:0]),
      .state_o  (cmd_state),
      .cmd_o    (cmd_o)
   );

   // ---------------- read mux ----------------
   logic [31:0] stat_rd, cause_rd, mask_rd, cmd_rd;

   always_comb begin
      stat_rd                = sts_i;
      stat_rd[STAT_DCTS_BIT] = dcts;
      stat_rd[STAT_CTS_BIT]  = cts_sync;

      cause_rd                             = '0;
      cause_rd[N_SRC-1:0]                  = pend & mask;
      cause_rd[CAUSE_RAW_LSB +: N_SRC]     = pend;

      mask_rd            = '0;
      mask_rd[N_SRC-1:0] = mask;

      cmd_rd            = '0;
      cmd_rd[CMD_W-1:0] = cmd_state;
   end

   always_comb begin
      bus_rdata_o = '0;
      if (hit) begin
         unique case (idx)
            RI_CTRL:          bus_rdata_o = ctrl_q;
            RI_STAT:          bus_rdata_o = stat_rd;
            RI_DATA:          bus_rdata_o = {24'd0, rx_byte_i};
            RI_MASK:          bus_rdata_o = mask_rd;
            RI_CAUSE:         bus_rdata_o = cause_rd;
            RI_TRIG:          bus_rdata_o = trig_q;
            RI_CSET, RI_CCLR: bus_rdata_o = cmd_rd;
            default:          bus_rdata_o = '0;
         endcase
      end
   end

   logic unused_addr_lsb;
   assign unused_addr_lsb = ^bus_addr_i[1:0];

   p_push_one_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(tx_push_o && rx_pop_o));

endmodule

// File: tb/uart_regblk_tb_top.sv
module uart_regblk_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [9:0]  evt = '0;
   logic [31:0] sts = '0;
   logic        cts_n = 1'b1;
   logic [7:0]  rx_byte = 8'h3C;
   logic        rx_pop, tx_push, uart_en, loop_en, irq;
   logic [7:0]  tx_byte, cmd;
   logic [31:0] ctrl;
   logic [4:0]  trig_rx, afc_lvl;
   logic [3:0]  trig_tx;

   always #10 clk = ~clk;   // 50 MHz

   uart_regblk dut_i (
      .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
      .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
      .evt_i(evt), .sts_i(sts), .cts_n_i(cts_n), .rx_byte_i(rx_byte),
      .rx_pop_o(rx_pop), .tx_push_o(tx_push), .tx_byte_o(tx_byte),
      .ctrl_o(ctrl), .uart_en_o(uart_en), .loop_en_o(loop_en),
      .trig_rx_o(trig_rx), .trig_tx_o(trig_tx), .afc_lvl_o(afc_lvl),
      .cmd_o(cmd), .irq_o(irq)
   );

   int unsigned n_chk = 0, n_err = 0;
   logic [9:0]  m_pend = '0, m_mask = '0;
   logic [7:0]  m_cmd = '0;
   logic        s_irq, s_push, s_pop;
   logic [7:0]  s_cmd, s_txb;
   logic [31:0] rd;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_cause(input logic [9:0] p, input logic [9:0] m);
      return {6'd0, p, 6'd0, p & m};
   endfunction

   // one bus cycle: drive at negedge, snapshot, model update at edge
   task automatic op(input logic sel, input logic wr, input logic [4:0] a,
                     input logic [31:0] d, input logic [9:0] ev, output logic [31:0] r);
      @(negedge clk);
      bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d; evt = ev;
      #1;
      r = bus_rdata; s_irq = irq; s_cmd = cmd; s_push = tx_push; s_pop = rx_pop; s_txb = tx_byte;
      @(posedge clk);
      if (sel && wr) begin
         case (a)
            5'h0C: m_mask = d[9:0];
            5'h10: m_pend = m_pend & ~(d[9:0] | d[25:16]);
            5'h18: m_cmd  = m_cmd | (d[7:0] & 8'h3F);
            5'h1C: m_cmd  = m_cmd & ~(d[7:0] & 8'h3F);
            default: ;
         endcase
      end
      m_pend = m_pend | ev;
      #1;
      bus_sel = 1'b0; bus_wr = 1'b0; evt = '0;
   endtask

   task automatic post_chk(input string tag);
      @(negedge clk); #1;
      chk({tag, " R4 irq"}, {31'd0, irq}, {31'd0, |(m_pend & m_mask)});
      chk({tag, " R7 cmd_o"}, {24'd0, cmd}, {24'd0, m_cmd});
   endtask

   initial begin : watchdog
      #(20 * 200000);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : main
      logic [31:0] e;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         if (a == 2) continue;
         op(1, 0, 5'(a * 4), 0, 0, rd);
         chk($sformatf("R1 reset read off %0h", a * 4), rd, (a == 1) ? 32'h0200_0000 : 32'h0);
      end
      chk("R1 irq/cmd reset", {23'd0, s_irq, s_cmd}, 32'd0);

      // R2 / R11 control and triggers
      op(1, 1, 5'h00, 32'h0100_0001, 0, rd);
      op(1, 0, 5'h00, 0, 0, rd);
      chk("R2 ctrl readback", rd, 32'h0100_0001);
      chk("R11 enables", {30'd0, uart_en, loop_en}, 32'd3);
      op(1, 1, 5'h00, 32'hA5A5_5A5A, 0, rd);
      op(1, 0, 5'h00, 0, 0, rd);
      chk("R2 ctrl full word", rd, 32'hA5A5_5A5A);
      chk("R11 ctrl_o/enables", {ctrl[31:2], uart_en, loop_en}, {30'h2969_5696, 1'b0, 1'b1});
      op(1, 1, 5'h14, 32'hFFFF_FFFF, 0, rd);
      op(1, 0, 5'h14, 0, 0, rd);
      chk("R2 triggers masked", rd, 32'h001F_0F1F);
      op(1, 1, 5'h14, 32'h0014_0310, 0, rd);
      chk("R2 trigger fields", {18'd0, afc_lvl, trig_tx, trig_rx}, {18'd0, 5'd20, 4'd3, 5'd16});

      // R7 command levels
      op(1, 1, 5'h18, 32'h2D, 0, rd);
      op(1, 0, 5'h18, 0, 0, rd);
      chk("R7 set readback", rd, 32'h2D);
      op(1, 1, 5'h1C, 32'h05, 0, rd);
      op(1, 0, 5'h1C, 0, 0, rd);
      chk("R7 clear readback at 0x1C", rd, 32'h28);
      op(1, 1, 5'h18, 32'h0, 0, rd);
      op(1, 1, 5'h1C, 32'h0, 0, rd);
      op(1, 0, 5'h18, 0, 0, rd);
      chk("R7 zero writes ignored", rd, 32'h28);
      chk("R7 cmd_o levels", {24'd0, s_cmd}, 32'h28);

      // R8 FIFO-reset strobes
      op(1, 1, 5'h18, 32'hC0, 0, rd);
      op(1, 0, 5'h18, 0, 0, rd);
      chk("R8 strobes read 0", rd, 32'h28);
      chk("R8 strobes high one cycle", {24'd0, s_cmd}, 32'hE8);
      op(0, 0, 0, 0, 0, rd);
      chk("R8 strobes dropped", {24'd0, s_cmd}, 32'h28);
      op(1, 1, 5'h1C, 32'hC0, 0, rd);
      op(0, 0, 0, 0, 0, rd);
      chk("R8 clear write no strobe", {24'd0, s_cmd}, 32'h28);

      // R10 data port
      op(1, 1, 5'h08, 32'h0000_12A5, 0, rd);
      chk("R10 push strobe/byte", {23'd0, s_push, s_txb}, {23'd0, 1'b1, 8'hA5});
      chk("R10 no pop on write", {31'd0, s_pop}, 32'd0);
      op(1, 0, 5'h08, 0, 0, rd);
      chk("R10 rx byte read", rd, 32'h3C);
      chk("R10 pop strobe", {30'd0, s_pop, s_push}, 32'd2);

      // R9 status and CTS
      sts = 32'hFFFF_FFFF;
      op(1, 0, 5'h04, 0, 0, rd);
      chk("R9 status passthrough", rd, 32'hFEFF_FFFF);
      sts = 32'h1234_5678;
      @(negedge clk) cts_n = 1'b0;
      repeat (6) @(posedge clk);
      m_pend[0] = 1'b1;
      op(1, 0, 5'h04, 0, 0, rd);
      chk("R9 cts asserted, change flagged", rd, 32'h1134_5678);
      op(1, 0, 5'h10, 0, 0, rd);
      chk("R9 change raises source 0", rd, exp_cause(m_pend, m_mask));
      op(1, 1, 5'h04, 32'h0100_0000, 0, rd);
      op(1, 0, 5'h04, 0, 0, rd);
      chk("R9 change flag cleared", rd, 32'h1034_5678);
      op(1, 1, 5'h10, 32'h0001_0000, 0, rd);
      op(1, 0, 5'h10, 0, 0, rd);
      chk("R5 raw-half ack", rd, 32'h0);

      // R3 / R4 / R5 directed
      op(1, 1, 5'h0C, 32'h0, 0, rd);
      op(0, 0, 0, 0, 10'h008, rd);
      op(1, 0, 5'h10, 0, 0, rd);
      chk("R3 raw latched while masked", rd, 32'h0008_0000);
      chk("R4 irq low while masked", {31'd0, s_irq}, 32'd0);
      op(1, 1, 5'h0C, 32'h008, 0, rd);
      chk("R4 irq unchanged in write cycle", {31'd0, s_irq}, 32'd0);
      post_chk("after mask write");
      op(1, 0, 5'h10, 0, 0, rd);
      chk("R4 masked half", rd, 32'h0008_0008);
      op(1, 1, 5'h10, 32'h0, 0, rd);
      op(1, 0, 5'h10, 0, 0, rd);
      chk("R5 zero write keeps pending", rd, 32'h0008_0008);
      op(1, 1, 5'h10, rd, 0, rd);
      chk("R4 irq held through ack cycle", {31'd0, s_irq}, 32'd1);
      post_chk("after ack");
      op(1, 0, 5'h10, 0, 0, rd);
      chk("R5 write-back clears", rd, 32'h0);

      // R6 event beats ack
      op(1, 1, 5'h0C, 32'h3FF, 0, rd);
      op(0, 0, 0, 0, 10'h004, rd);
      op(1, 1, 5'h10, 32'h0000_0004, 10'h004, rd);
      op(1, 0, 5'h10, 0, 0, rd);
      chk("R6 collision stays pending", rd, 32'h0004_0004);
      op(1, 1, 5'h10, 32'h0004_0004, 10'h200, rd);
      op(1, 0, 5'h10, 0, 0, rd);
      chk("R6 other source unaffected", rd, 32'h0200_0200);
      op(1, 1, 5'h10, rd, 0, rd);

      // random phase: R3 R4 R5 R6 R7
      for (int i = 0; i < 400; i++) begin
         logic [9:0]  ev;
         logic [31:0] d;
         int unsigned kind;
         ev   = ($urandom % 3 == 0) ? 10'($urandom) : 10'd0;
         kind = $urandom % 5;
         d    = $urandom;
         case (kind)
            0: op(1, 1, 5'h0C, d, ev, rd);
            1: begin
               if (d[0]) d = exp_cause(m_pend, m_mask);
               op(1, 1, 5'h10, d, ev, rd);
            end
            2: begin
               e = exp_cause(m_pend, m_mask);
               op(1, 0, 5'h10, 0, ev, rd);
               chk("R3/R4 random cause read", rd, e);
            end
            3: op(0, 0, 0, 0, ev, rd);
            default: op(1, 1, d[8] ? 5'h18 : 5'h1C, d & 32'h3F, ev, rd);
         endcase
         post_chk("random");
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule